// File: doc/BRIEF.md
# Masked Time Alarm and Interrupt Flag Unit

This block watches the running clock/calendar fields (BCD seconds, minutes, hours, day of week and date of month) and compares them against four host-programmable alarm bytes each time the one-cycle second strobe arrives. Each alarm byte carries a mask bit in its top position. The four mask bits, together with a day-or-date select bit in the fourth alarm byte, pick one of six alarm rates. A qualifying match raises a time-of-day alarm flag.

The alarm flag, a kickstart flag and a watchdog flag are gated by enable bits in a control byte. The gated result drives an active-low interrupt and is mirrored as an interrupt-request bit. The alarm flag (when its power enable is set) or the kickstart flag also pulls a power-request output low until the host releases it. A read of the status byte clears all flags, but only when that read access ends. Writing a zero to a flag also clears it. The two battery-low bits are plain inputs that show up in the status byte.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the status byte (address 4) reads 0x10 with both battery inputs low, the control byte (address 5) reads 0x80, and both irq_n and pwr_n are 1.
- R2: With mask bits {byte3[7],byte2[7],byte1[7],byte0[7]} = 1111, or any pattern other than 1110, 1100, 1000 or 0000, every tick sets the alarm flag (status bit 3) whatever the time.
- R3: Mask 1110 sets the alarm flag on a tick only when cur_sec[6:0] equals alarm byte 0 [6:0].
- R4: Mask 1100 also requires cur_min[6:0] to equal byte 1 [6:0]. Mask 1000 further requires cur_hour[5:0] to equal byte 2 [5:0].
- R5: Mask 0000 also requires a day match on byte 3 [5:0]. Byte 3 bit 6 = 1 compares it with cur_dow[5:0], and bit 6 = 0 compares it with cur_dom[5:0].
- R6: The alarm flag changes only on a cycle where tick is high. A matching time without a tick sets nothing.
- R7: Status bit 0 and irq_n reflect (alarm flag AND control bit 3) OR (kickstart flag, status bit 2, AND control bit 2) OR (watchdog flag, status bit 1, AND control bit 1). irq_n is low exactly when that term is 1.
- R8: A status read (bus_rd high with address 4) clears status bits 3..1 at the clock edge where that access ends, either because bus_rd drops or because the address changes. The flags stay set while the access continues.
- R9: Writing the status byte with bit 3, 2 or 1 at 0 clears that flag. Writing 1 to bit 2 sets the kickstart flag. Writing 1 to bit 3 or bit 1 has no effect. kick_evt sets the kickstart flag and wdog_evt sets the watchdog flag.
- R10: A flag-setting event in the same cycle as a clearing write or read end leaves the flag set.
- R11: Status bit 4 drives pwr_n. It is cleared one edge after the alarm flag is set with control bit 4 set, or after the kickstart flag is set. A host status write sets it to bit 4 of the written value, and that write takes precedence over the automatic clear in the same cycle.
- R12: Status bit 7 follows batt_low_main and bit 6 follows batt_low_aux. Bit 5 holds the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle second strobe |
| cur_sec | input | 8 | Running seconds, BCD |
| cur_min | input | 8 | Running minutes, BCD |
| cur_hour | input | 8 | Running hours, BCD 24-hour |
| cur_dow | input | 8 | Running day of week |
| cur_dom | input | 8 | Running date of month, BCD |
| kick_evt | input | 1 | Kickstart event pulse |
| wdog_evt | input | 1 | Watchdog timeout pulse |
| batt_low_main | input | 1 | Main battery low indication |
| batt_low_aux | input | 1 | Auxiliary battery low indication |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read access active |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| ctrl_q | output | 8 | Control byte for neighbouring logic |
| irq_n | output | 1 | Active-low interrupt |
| pwr_n | output | 1 | Active-low power request |

## Verification
Register writes, tick-driven alarm matches and event pulses show up at the ports right after the edge that samples them. The bench drives stimulus on the falling edge and observes at the next falling edge. The read-clear lands on the edge where the status access ends. The power-request drop comes one edge after its flag, so the bench samples pwr_n both before and after that edge. Read data is combinational, so values are peeked mid-cycle with bus_rd low, which leaves no side effect. The alarm rates are swept over all 16 mask patterns, both day/date selects and six time variants, each scored against an arithmetic model.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   typedef enum logic [2:0] {
      RATE_EVERY,
      RATE_SEC,
      RATE_MIN_SEC,
      RATE_HMS,
      RATE_FULL
   } alarm_rate_t;

   // status byte bit positions
   localparam int ST_BLF_MAIN = 7;
   localparam int ST_BLF_AUX  = 6;
   localparam int ST_PRS      = 5;
   localparam int ST_PAB      = 4;
   localparam int ST_TDF      = 3;
   localparam int ST_KSF      = 2;
   localparam int ST_WDF      = 1;
   localparam int ST_IRQF     = 0;

   // control byte bit positions used here
   localparam int CT_TPE = 4;
   localparam int CT_TIE = 3;
   localparam int CT_KIE = 2;
   localparam int CT_WDE = 1;

   // mask pattern {day,hour,min,sec} -> rate; unlisted patterns fall back
   function automatic alarm_rate_t decode_rate(input logic [3:0] m);
      alarm_rate_t r;
      case (m)
         4'b1111: r = RATE_EVERY;
         4'b1110: r = RATE_SEC;
         4'b1100: r = RATE_MIN_SEC;
         4'b1000: r = RATE_HMS;
         4'b0000: r = RATE_FULL;
         default: r = RATE_EVERY;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_alarm_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int NUM_ALM = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_ALM-1:0]             alm_we,
   input  logic [DATA_W-1:0]              wdata,
   input  logic                           tick,
   input  logic [DATA_W-1:0]              cur_sec,
   input  logic [DATA_W-1:0]              cur_min,
   input  logic [DATA_W-1:0]              cur_hour,
   input  logic [DATA_W-1:0]              cur_dow,
   input  logic [DATA_W-1:0]              cur_dom,
   output logic [NUM_ALM-1:0][DATA_W-1:0] alm_q,
   output logic                           hit_tick
);

   localparam int MASK_BIT = DATA_W - 1;
   localparam int SEL_BIT  = DATA_W - 2;
   localparam logic [DATA_W-1:0] F_MS = DATA_W'(8'h7F);
   localparam logic [DATA_W-1:0] F_HD = DATA_W'(8'h3F);

   if (NUM_ALM != 4) begin : g_bad_num
      initial $fatal(1, "rtc_alarm_cmp needs exactly four alarm bytes");
   end

   for (genvar i = 0; i < NUM_ALM; i++) begin : g_alm
      always_ff @(posedge clk) begin
         if (!rst_n)         alm_q[i] <= '0;
         else if (alm_we[i]) alm_q[i] <= wdata;
      end
   end

   logic [NUM_ALM-1:0] mask;
   for (genvar i = 0; i < NUM_ALM; i++) begin : g_mask
      assign mask[i] = alm_q[i][MASK_BIT];
   end

   logic              eq_s, eq_m, eq_h, eq_d;
   logic [DATA_W-1:0] day_tgt;
   alarm_rate_t       rate;
   logic              hit;

   assign day_tgt = alm_q[3][SEL_BIT] ? cur_dow : cur_dom;
   assign eq_s    = (alm_q[0] & F_MS) == (cur_sec  & F_MS);
   assign eq_m    = (alm_q[1] & F_MS) == (cur_min  & F_MS);
   assign eq_h    = (alm_q[2] & F_HD) == (cur_hour & F_HD);
   assign eq_d    = (alm_q[3] & F_HD) == (day_tgt  & F_HD);
   assign rate    = decode_rate(mask);

   always_comb begin
      case (rate)
         RATE_SEC:     hit = eq_s;
         RATE_MIN_SEC: hit = eq_s & eq_m;
         RATE_HMS:     hit = eq_s & eq_m & eq_h;
         RATE_FULL:    hit = eq_s & eq_m & eq_h & eq_d;
         default:      hit = 1'b1;
      endcase
   end

   assign hit_tick = tick & hit;

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
   import rtc_alarm_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int ADR_STAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_tdf,
   input  logic              kick_evt,
   input  logic              wdog_evt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [5:1]        stat_wdata,
   input  logic              en_tpe,
   input  logic              en_tie,
   input  logic              en_kie,
   input  logic              en_wde,
   output logic              tdf,
   output logic              ksf,
   output logic              wdf,
   output logic              pab,
   output logic              prs,
   output logic              irqf
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

   logic stat_rd, stat_wr, rd_pend, rd_done;
   logic clr_tdf, clr_ksf, clr_wdf;

   assign stat_rd = bus_rd && (bus_addr == A_STAT);
   assign stat_wr = bus_wr && (bus_addr == A_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) rd_pend <= 1'b0;
      else        rd_pend <= stat_rd;
   end

   // access ended: was reading status last cycle, not any more
   assign rd_done = rd_pend && !stat_rd;

   assign clr_tdf = rd_done | (stat_wr & ~stat_wdata[ST_TDF]);
   assign clr_ksf = rd_done | (stat_wr & ~stat_wdata[ST_KSF]);
   assign clr_wdf = rd_done | (stat_wr & ~stat_wdata[ST_WDF]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tdf <= 1'b0;
         ksf <= 1'b0;
         wdf <= 1'b0;
      end else begin
         tdf <= set_tdf | (tdf & ~clr_tdf);
         ksf <= kick_evt | (stat_wr & stat_wdata[ST_KSF]) | (ksf & ~clr_ksf);
         wdf <= wdog_evt | (wdf & ~clr_wdf);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pab <= 1'b1;
         prs <= 1'b0;
      end else if (stat_wr) begin
         pab <= stat_wdata[ST_PAB];
         prs <= stat_wdata[ST_PRS];
      end else if ((tdf & en_tpe) | ksf) begin
         pab <= 1'b0;
      end
   end

   assign irqf = (tdf & en_tie) | (ksf & en_kie) | (wdf & en_wde);

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
   import rtc_alarm_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter int          ADDR_W   = 3,
   parameter int          ADR_ALM0 = 0,
   parameter int          ADR_STAT = 4,
   parameter int          ADR_CTRL = 5,
   parameter logic [7:0]  CTRL_RST = 8'h80,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [DATA_W-1:0] cur_sec,
   input  logic [DATA_W-1:0] cur_min,
   input  logic [DATA_W-1:0] cur_hour,
   input  logic [DATA_W-1:0] cur_dow,
   input  logic [DATA_W-1:0] cur_dom,
   input  logic              kick_evt,
   input  logic              wdog_evt,
   input  logic              batt_low_main,
   input  logic              batt_low_aux,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              irq_n,
   output logic              pwr_n
);

   localparam int NUM_ALM = 4;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);

   if (DATA_W != 8) begin : g_bad_w
      initial $fatal(1, "rtc_alarm_irq fields assume byte-wide registers");
   end
   if ((ADR_ALM0 + NUM_ALM > (1 << ADDR_W)) || (ADR_STAT >= (1 << ADDR_W)) ||
       (ADR_CTRL >= (1 << ADDR_W))) begin : g_bad_a
      initial $fatal(1, "rtc_alarm_irq address map exceeds ADDR_W");
   end
   if ((ADR_STAT == ADR_CTRL) ||
       ((ADR_STAT >= ADR_ALM0) && (ADR_STAT < ADR_ALM0 + NUM_ALM)) ||
       ((ADR_CTRL >= ADR_ALM0) && (ADR_CTRL < ADR_ALM0 + NUM_ALM))) begin : g_bad_o
      initial $fatal(1, "rtc_alarm_irq address map overlaps");
   end

   // write decode
   logic [NUM_ALM-1:0] alm_we;
   for (genvar i = 0; i < NUM_ALM; i++) begin : g_we
      assign alm_we[i] = bus_wr && (bus_addr == ADDR_W'(ADR_ALM0 + i));
   end

   // control byte
   always_ff @(posedge clk) begin
      if (!rst_n)                              ctrl_q <= CTRL_RST;
      else if (bus_wr && (bus_addr == A_CTRL)) ctrl_q <= bus_wdata;
   end

   logic [NUM_ALM-1:0][DATA_W-1:0] alm_q;
   logic                           tdf_set;

   rtc_alarm_cmp #(
      .DATA_W (DATA_W),
      .NUM_ALM(NUM_ALM)
   ) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .alm_we  (alm_we),
      .wdata   (bus_wdata),
      .tick    (tick),
      .cur_sec (cur_sec),
      .cur_min (cur_min),
      .cur_hour(cur_hour),
      .cur_dow (cur_dow),
      .cur_dom (cur_dom),
      .alm_q   (alm_q),
      .hit_tick(tdf_set)
   );

   logic flag_tdf, flag_ksf, flag_wdf, flag_pab, flag_prs, flag_irqf;

   rtc_irq_flags #(
      .ADDR_W  (ADDR_W),
      .ADR_STAT(ADR_STAT)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_tdf   (tdf_set),
      .kick_evt  (kick_evt),
      .wdog_evt  (wdog_evt),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .stat_wdata(bus_wdata[5:1]),
      .en_tpe    (ctrl_q[CT_TPE]),
      .en_tie    (ctrl_q[CT_TIE]),
      .en_kie    (ctrl_q[CT_KIE]),
      .en_wde    (ctrl_q[CT_WDE]),
      .tdf       (flag_tdf),
      .ksf       (flag_ksf),
      .wdf       (flag_wdf),
      .pab       (flag_pab),
      .prs       (flag_prs),
      .irqf      (flag_irqf)
   );

   logic [DATA_W-1:0] stat_byte;
   always_comb begin
      stat_byte              = '0;
      stat_byte[ST_BLF_MAIN] = batt_low_main;
      stat_byte[ST_BLF_AUX]  = batt_low_aux;
      stat_byte[ST_PRS]      = flag_prs;
      stat_byte[ST_PAB]      = flag_pab;
      stat_byte[ST_TDF]      = flag_tdf;
      stat_byte[ST_KSF]      = flag_ksf;
      stat_byte[ST_WDF]      = flag_wdf;
      stat_byte[ST_IRQF]     = flag_irqf;
   end

   // read mux, independent of bus_rd
   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_ALM; i++) begin
         if (bus_addr == ADDR_W'(ADR_ALM0 + i)) bus_rdata = alm_q[i];
      end
      if (bus_addr == A_STAT) bus_rdata = stat_byte;
      if (bus_addr == A_CTRL) bus_rdata = ctrl_q;
   end

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk) begin
         if (!rst_n) irq_n <= 1'b1;
         else        irq_n <= ~flag_irqf;
      end
   end else begin : g_irq_comb
      assign irq_n = ~flag_irqf;
   end

   assign pwr_n = flag_pab;

endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk #(
   parameter int ADDR_W   = 3,
   parameter int ADR_STAT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              kick_evt,
   input logic              wdog_evt,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wd_pab,
   input logic              wd_tdf,
   input logic              tdf,
   input logic              ksf,
   input logic              wdf,
   input logic              tpe,
   input logic              irq_n,
   input logic              pwr_n
);

   logic stat_rd, stat_wr;
   assign stat_rd = bus_rd && (bus_addr == ADDR_W'(ADR_STAT));
   assign stat_wr = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));

   AST_TDF_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tdf) |-> $past(tick)); // R6

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (tdf || ksf || wdf)); // R7

   AST_TDF_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tdf) |-> ($past(stat_wr && !wd_tdf) ||
                      ($past(!stat_rd) && $past(stat_rd, 2)))); // R8

   AST_WDF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdf) |-> $past(wdog_evt)); // R9

   AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      kick_evt |=> ksf); // R10

   AST_PWR_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_n) |-> ($past((tdf && tpe) || ksf) || $past(stat_wr && !wd_pab))); // R11

   AST_PWR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_n) |-> $past(stat_wr && wd_pab)); // R11

endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(
   .ADDR_W  (ADDR_W),
   .ADR_STAT(ADR_STAT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .kick_evt(kick_evt),
   .wdog_evt(wdog_evt),
   .bus_rd  (bus_rd),
   .bus_wr  (bus_wr),
   .bus_addr(bus_addr),
   .wd_pab  (bus_wdata[4]),
   .wd_tdf  (bus_wdata[3]),
   .tdf     (flag_tdf),
   .ksf     (flag_ksf),
   .wdf     (flag_wdf),
   .tpe     (ctrl_q[4]),
   .irq_n   (irq_n),
   .pwr_n   (pwr_n)
);

// File: tb/sim_rtc_alarm_irq.sv
module sim_rtc_alarm_irq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_dow = '0, cur_dom = '0;
   logic       kick_evt = 1'b0, wdog_evt = 1'b0;
   logic       batt_low_main = 1'b0, batt_low_aux = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata, ctrl_q;
   logic       irq_n, pwr_n;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   rtc_alarm_irq u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
      .cur_dow(cur_dow), .cur_dom(cur_dom),
      .kick_evt(kick_evt), .wdog_evt(wdog_evt),
      .batt_low_main(batt_low_main), .batt_low_aux(batt_low_aux),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_q(ctrl_q),
      .irq_n(irq_n), .pwr_n(pwr_n)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // mid-cycle look at read data, no read access
   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   function automatic bit model_hit(input int mask, input int dy, input int v);
      bit s, m, h, d;
      s = (v != 1); m = (v != 2); h = (v != 3);
      d = dy ? (v != 5) : (v != 4);
      case (mask)
         15:      return 1'b1;
         14:      return s;
         12:      return s & m;
         8:       return s & m & h;
         0:       return s & m & h & d;
         default: return 1'b1;
      endcase
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek(3'd4, r); chk("R1 status", r, 8'h10);
      peek(3'd5, r); chk("R1 control", r, 8'h80);
      chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
      chk("R1 pwr_n", {7'd0, pwr_n}, 8'h01);

      // R12 battery bits and PRS
      batt_low_main = 1'b1;
      peek(3'd4, r); chk("R12 main", r, 8'h90);
      batt_low_main = 1'b0; batt_low_aux = 1'b1;
      peek(3'd4, r); chk("R12 aux", r, 8'h50);
      batt_low_aux = 1'b0;
      wr(3'd4, 8'h30);
      peek(3'd4, r); chk("R12 prs", r, 8'h30);
      wr(3'd4, 8'h10);

      // R2..R5 sweep over masks, day/date select and time variants
      for (int mask = 0; mask < 16; mask++) begin
         for (int dy = 0; dy < 2; dy++) begin
            for (int v = 0; v < 6; v++) begin
               string tag;
               bit    e;
               wr(3'd0, {mask[0], 7'h25});
               wr(3'd1, {mask[1], 7'h41});
               wr(3'd2, {mask[2], 7'h13});
               wr(3'd3, {mask[3], dy[0], 6'h07});
               wr(3'd4, 8'h10);
               cur_sec  = (v == 1) ? 8'h26 : 8'h25;
               cur_min  = (v == 2) ? 8'h42 : 8'h41;
               cur_hour = (v == 3) ? 8'h14 : 8'h13;
               cur_dom  = (v == 4) ? 8'h15 : 8'h07;
               cur_dow  = (v == 5) ? 8'h03 : 8'h07;
               pulse_tick();
               e = model_hit(mask, dy, v);
               tag = (mask == 14) ? "R3" : (mask == 12 || mask == 8) ? "R4" :
                     (mask == 0) ? "R5" : "R2";
               peek(3'd4, r);
               chk(tag, {7'd0, r[3]}, {7'd0, e});
            end
         end
      end
      chk("R11 no tpe", {7'd0, pwr_n}, 8'h01);

      // R6 match without tick
      wr(3'd0, 8'h25); wr(3'd1, 8'h41); wr(3'd2, 8'h13); wr(3'd3, 8'h07);
      cur_sec = 8'h25; cur_min = 8'h41; cur_hour = 8'h13; cur_dom = 8'h07; cur_dow = 8'h07;
      wr(3'd4, 8'h10);
      repeat (5) @(negedge clk);
      peek(3'd4, r); chk("R6 no tick", r, 8'h10);
      pulse_tick();
      peek(3'd4, r); chk("R6 tick", r, 8'h18);

      // R7 alarm interrupt enable
      chk("R7 tie off", {7'd0, irq_n}, 8'h01);
      wr(3'd5, 8'h88);
      chk("R7 tie on", {7'd0, irq_n}, 8'h00);
      peek(3'd4, r); chk("R7 irqf", r, 8'h19);

      // R8 long read, end by address change
      @(negedge clk); bus_addr = 3'd4; bus_rd = 1'b1;
      repeat (3) @(negedge clk);
      #1 chk("R8 held", bus_rdata, 8'h19);
      @(negedge clk); bus_addr = 3'd5;
      @(negedge clk); bus_rd = 1'b0;
      peek(3'd4, r); chk("R8 addr end", r, 8'h10);
      chk("R8 irq_n", {7'd0, irq_n}, 8'h01);

      // R7/R8 kickstart, read ends by bus_rd dropping
      wr(3'd5, 8'h84);
      @(negedge clk); kick_evt = 1'b1;
      @(negedge clk); kick_evt = 1'b0;
      chk("R7 kie", {7'd0, irq_n}, 8'h00);
      peek(3'd4, r); chk("R7 ksf", r, 8'h15);
      @(negedge clk); bus_addr = 3'd4; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0;
      @(negedge clk);
      peek(3'd4, r); chk("R8 rd end", {4'd0, r[3:0]}, 8'h00);
      chk("R11 ksf drop", {7'd0, pwr_n}, 8'h00);
      wr(3'd4, 8'h10);

      // R7 watchdog, R9 clear by write
      wr(3'd5, 8'h82);
      @(negedge clk); wdog_evt = 1'b1;
      @(negedge clk); wdog_evt = 1'b0;
      chk("R7 wde", {7'd0, irq_n}, 8'h00);
      wr(3'd5, 8'h80);
      chk("R7 wde off", {7'd0, irq_n}, 8'h01);
      peek(3'd4, r); chk("R9 wdf set", r, 8'h12);
      wr(3'd4, 8'h10);
      peek(3'd4, r); chk("R9 wdf clr", r, 8'h10);

      // R9 write 1 to ksf sets; R11 pab follows
      wr(3'd4, 8'h14);
      peek(3'd4, r); chk("R9 ksf wr1", r, 8'h14);
      @(negedge clk);
      peek(3'd4, r); chk("R11 pab auto", r, 8'h04);
      chk("R11 pwr_n", {7'd0, pwr_n}, 8'h00);
      wr(3'd4, 8'h1A);
      peek(3'd4, r); chk("R9 wr1 ignored", r, 8'h10);
      @(negedge clk);
      chk("R11 release", {7'd0, pwr_n}, 8'h01);

      // R10 kick same cycle as clearing write
      @(negedge clk); bus_addr = 3'd4; bus_wdata = 8'h10; bus_wr = 1'b1; kick_evt = 1'b1;
      @(negedge clk); bus_wr = 1'b0; kick_evt = 1'b0;
      peek(3'd4, r); chk("R10 write", {5'd0, r[2], 2'd0}, 8'h04);
      wr(3'd4, 8'h10);
      // R10 kick same cycle as read end
      @(negedge clk); bus_addr = 3'd4; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0; kick_evt = 1'b1;
      @(negedge clk); kick_evt = 1'b0;
      peek(3'd4, r); chk("R10 read end", {5'd0, r[2], 2'd0}, 8'h04);
      wr(3'd4, 8'h10);
      @(negedge clk);
      peek(3'd4, r); chk("R10 cleanup", r, 8'h10);

      // R11 alarm with power enable
      wr(3'd5, 8'h90);
      pulse_tick();
      chk("R11 tdf edge", {7'd0, pwr_n}, 8'h01);
      @(negedge clk);
      chk("R11 tdf tpe", {7'd0, pwr_n}, 8'h00);
      wr(3'd4, 8'h10);
      chk("R11 write wins", {7'd0, pwr_n}, 8'h01);
      repeat (2) @(negedge clk);
      chk("R11 stays", {7'd0, pwr_n}, 8'h01);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule